// File: doc/BRIEF.md
# Keyed Configuration Port Decoder

This block is a configuration register unit that a host reaches through a pair of byte-wide I/O ports: an index port that picks a register and a data port, one address above it, that reads or writes the picked register. The unit stays locked until the host writes an entry key to the index port. It locks again when the host writes an exit key. While it is locked, the index port does not echo what was written to it, and the data port neither accepts writes nor returns register contents. A host can therefore probe for the unit by entering the key, writing an index and reading it back.

While unlocked, the unit provides a fixed identification byte, a revision byte, a logical-device selector, and a small bank of per-device registers. Only one logical device, the mailbox, is implemented. Its bank holds an activate bit and a 16-bit I/O base address, and both are driven straight out of the block for the mailbox decoder. A strap input chooses which of two candidate index addresses the unit answers on.

Top module: `cfgport_decoder`

## Requirements
- R1: With `strap_alt`=0 the index port is at 0x2E, and with `strap_alt`=1 it is at 0x4E. The data port is at the index address plus one. Accesses to any other address change no state, and a read there returns 0xFF.
- R2: While the unit is locked, writing 0x55 to the index port unlocks it. Any other value written to the index port while locked leaves the unit locked and is not stored.
- R3: While the unit is unlocked, writing 0xAA to the index port locks it and leaves the stored index unchanged. Any other value written to the index port is stored as the new index.
- R4: Reading the index port returns 0xFF while the unit is locked and returns the stored index while it is unlocked.
- R5: While the unit is locked, data-port writes are ignored and data-port reads return 0xFF.
- R6: Register 0x20 reads the device ID (parameter, default 0x4D) and register 0x21 reads the revision (parameter, default 0x01). Both are read-only.
- R7: Register 0x07 is a global read/write logical-device selector.
- R8: Registers 0x30 (bit 0 = activate, other bits read 0), 0x60 (base high byte) and 0x61 (base low byte) reach the mailbox only while the selector equals 9. For any other selector value they read 0x00 and ignore writes.
- R9: After reset the unit is locked, the stored index and the selector are 0x00, the mailbox is inactive, and its base is the parameter default (0x0A00).
- R10: When a read and a write reach the unit in the same cycle, the read returns the state as it was before that write.
- R11: `mbx_active` and `mbx_base` follow the mailbox registers and change in the cycle after the write that sets them.
- R12: Unmapped register indices read 0x00 while the unit is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_alt | input | 1 | Selects the alternate index address |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational from current state |
| mbx_active | output | 1 | Mailbox logical device activated |
| mbx_base | output | 16 | Mailbox I/O base address |

## Verification
A read of the index port and a write of the exit key can fall in the same cycle, and so can a data-port read and a data-port write to the same register. The bench drives both strobes together. It expects the read to return the stored index (or the old register value) in that cycle, and it expects the new state, locked or updated, to show on the next access. A locked-mode data write is judged later, after the unit is unlocked again, by reading the register it would have changed.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [7:0] KEY_UNLOCK = 8'h55;
  localparam logic [7:0] KEY_LOCK   = 8'hAA;
  localparam logic [7:0] REG_LDSEL  = 8'h07;
  localparam logic [7:0] REG_DEVID  = 8'h20;
  localparam logic [7:0] REG_REV    = 8'h21;
  localparam logic [7:0] REG_ACT    = 8'h30;
  localparam logic [7:0] REG_BASEH  = 8'h60;
  localparam logic [7:0] REG_BASEL  = 8'h61;
  localparam logic [7:0] IDLE_READ  = 8'hFF;
endpackage

// File: rtl/cfgport_addr_dec.sv
module cfgport_addr_dec #(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] IDX_PRI = 16'h002E,
  parameter logic [AW-1:0] IDX_ALT = 16'h004E
) (
  input  logic          strap_alt,
  input  logic [AW-1:0] addr,
  output logic          idx_hit,
  output logic          dat_hit
);
  localparam int unsigned NCAND = 2;
  logic [AW-1:0] cand [NCAND];
  logic [NCAND-1:0] idx_m, dat_m;

  assign cand[0] = IDX_PRI;
  assign cand[1] = IDX_ALT;

  for (genvar g = 0; g < NCAND; g++) begin : g_cand
    logic sel;
    assign sel      = (g == 1) ? strap_alt : !strap_alt;
    assign idx_m[g] = sel && (addr == cand[g]);
    assign dat_m[g] = sel && (addr == cand[g] + AW'(1));
  end

  assign idx_hit = |idx_m;
  assign dat_hit = |dat_m;
endmodule

// File: rtl/cfgport_key_fsm.sv
module cfgport_key_fsm
  import cfgport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              unlocked,
  output logic [BYTE_W-1:0] index
);
  logic              unl_q, unl_d;
  logic [BYTE_W-1:0] idx_q, idx_d;
  logic              idx_en;

  always_comb begin
    unl_d  = unl_q;
    idx_d  = idx_q;
    idx_en = 1'b0;
    if (idx_wr) begin
      if (!unl_q) begin
        if (wdata == KEY_UNLOCK) unl_d = 1'b1;
      end else if (wdata == KEY_LOCK) begin
        unl_d = 1'b0;
      end else begin
        idx_d  = wdata;
        idx_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unl_q <= 1'b0;
      idx_q <= '0;
    end else begin
      unl_q <= unl_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  assign unlocked = unl_q;
  assign index    = idx_q;

  // R2
  unlock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && !unlocked && wdata == KEY_UNLOCK) |=> unlocked);
  // R2
  stay_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && !unlocked && wdata != KEY_UNLOCK) |=> (!unlocked && $stable(index)));
  // R3
  lock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && unlocked && wdata == KEY_LOCK) |=> (!unlocked && $stable(index)));
endmodule

// File: rtl/cfgport_ldev_bank.sv
module cfgport_ldev_bank
  import cfgport_pkg::*;
#(
  parameter logic [BYTE_W-1:0] MBX_LDN = 8'd9,
  parameter logic [15:0] BASE_RST = 16'h0A00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] ldsel,
  output logic              mbx_on,
  output logic              act,
  output logic [15:0]       base
);
  logic [BYTE_W-1:0] ld_q, ld_d;
  logic              act_q, act_d;
  logic [15:0]       base_q, base_d;
  logic              ld_en, act_en, bh_en, bl_en;

  assign mbx_on = (ld_q == MBX_LDN);

  always_comb begin
    ld_en  = reg_wr && (reg_sel == REG_LDSEL);
    act_en = reg_wr && mbx_on && (reg_sel == REG_ACT);
    bh_en  = reg_wr && mbx_on && (reg_sel == REG_BASEH);
    bl_en  = reg_wr && mbx_on && (reg_sel == REG_BASEL);
    ld_d   = wdata;
    act_d  = wdata[0];
    base_d = base_q;
    if (bh_en) base_d[15:8] = wdata;
    if (bl_en) base_d[7:0]  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q   <= '0;
      act_q  <= 1'b0;
      base_q <= BASE_RST;
    end else begin
      if (ld_en) ld_q <= ld_d;
      if (act_en) act_q <= act_d;
      if (bh_en || bl_en) base_q <= base_d;
    end
  end

  assign ldsel = ld_q;
  assign act   = act_q;
  assign base  = base_q;

  // R8
  bank_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !mbx_on) |=> ($stable(act) && $stable(base)));
  // R11
  base_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && mbx_on && reg_sel == REG_BASEL) |=> (base[7:0] == $past(wdata)));
endmodule

// File: rtl/cfgport_decoder.sv
module cfgport_decoder
  import cfgport_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] IDX_PRI = 16'h002E,
  parameter logic [AW-1:0] IDX_ALT = 16'h004E,
  parameter logic [7:0] DEV_ID = 8'h4D,
  parameter logic [7:0] DEV_REV = 8'h01,
  parameter logic [7:0] MBX_LDN = 8'd9,
  parameter logic [15:0] BASE_RST = 16'h0A00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_alt,
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [7:0]    io_wdata,
  output logic [7:0]    io_rdata,
  output logic          mbx_active,
  output logic [15:0]   mbx_base
);
  logic idx_hit, dat_hit, unlocked, mbx_on, act;
  logic [7:0] index, ldsel, reg_rd;
  logic [15:0] base;

  cfgport_addr_dec #(.AW(AW), .IDX_PRI(IDX_PRI), .IDX_ALT(IDX_ALT)) u_dec (
    .strap_alt(strap_alt), .addr(io_addr), .idx_hit(idx_hit), .dat_hit(dat_hit)
  );

  cfgport_key_fsm u_key (
    .clk(clk), .rst_n(rst_n), .idx_wr(io_wr && idx_hit), .wdata(io_wdata),
    .unlocked(unlocked), .index(index)
  );

  cfgport_ldev_bank #(.MBX_LDN(MBX_LDN), .BASE_RST(BASE_RST)) u_bank (
    .clk(clk), .rst_n(rst_n), .reg_wr(io_wr && dat_hit && unlocked),
    .reg_sel(index), .wdata(io_wdata), .ldsel(ldsel), .mbx_on(mbx_on),
    .act(act), .base(base)
  );

  always_comb begin
    reg_rd = 8'h00;
    case (index)
      REG_LDSEL: reg_rd = ldsel;
      REG_DEVID: reg_rd = DEV_ID;
      REG_REV:   reg_rd = DEV_REV;
      REG_ACT:   reg_rd = mbx_on ? {7'd0, act} : 8'h00;
      REG_BASEH: reg_rd = mbx_on ? base[15:8] : 8'h00;
      REG_BASEL: reg_rd = mbx_on ? base[7:0] : 8'h00;
      default:   reg_rd = 8'h00;
    endcase
  end

  always_comb begin
    io_rdata = IDLE_READ;
    if (io_rd && unlocked) begin
      if (idx_hit)      io_rdata = index;
      else if (dat_hit) io_rdata = reg_rd;
    end
  end

  assign mbx_active = act;
  assign mbx_base   = base;

  // R5
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !unlocked && !idx_hit) |=> ($stable(mbx_base) && $stable(mbx_active)));
  // R1
  foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !idx_hit && !dat_hit) |=> ($stable(mbx_base) && $stable(mbx_active)));
endmodule

// File: tb/test_cfgport_decoder.sv
module test_cfgport_decoder;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, strap_alt = 1'b0;
  logic [15:0] io_addr = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic mbx_active;
  logic [15:0] mbx_base;
  int n_chk = 0, n_fail = 0;
  logic [15:0] ia = 16'h002E;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgport_decoder i_cfgport_decoder (
    .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .mbx_active(mbx_active), .mbx_base(mbx_base)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic reg_wr(logic [7:0] r, logic [7:0] d);
    wr(ia, r); wr(ia + 16'd1, d);
  endtask

  task automatic reg_rd(logic [7:0] r, output logic [7:0] d);
    wr(ia, r); rd(ia + 16'd1, d);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R9 active", {15'd0, mbx_active}, 16'h0000);
    check("R9 base", mbx_base, 16'h0A00);
    rd(ia, d); check("R4 locked index", {8'd0, d}, 16'h00FF);
    rd(ia + 16'd1, d); check("R5 locked data", {8'd0, d}, 16'h00FF);
  endtask

  task automatic t_keys;
    logic [7:0] d;
    wr(ia, 8'h20);
    rd(ia, d); check("R2 non-key stays locked", {8'd0, d}, 16'h00FF);
    wr(ia, 8'h55);
    rd(ia, d); check("R9 index reset / R2 not stored", {8'd0, d}, 16'h0000);
    wr(ia, 8'h20);
    rd(ia, d); check("R4 index readback", {8'd0, d}, 16'h0020);
    rd(ia + 16'd1, d); check("R6 device id", {8'd0, d}, 16'h004D);
    wr(ia + 16'd1, 8'h12);
    rd(ia + 16'd1, d); check("R6 id read-only", {8'd0, d}, 16'h004D);
    reg_rd(8'h21, d); check("R6 revision", {8'd0, d}, 16'h0001);
    reg_rd(8'h07, d); check("R9 selector reset", {8'd0, d}, 16'h0000);
  endtask

  task automatic t_mailbox;
    logic [7:0] d;
    reg_wr(8'h30, 8'h01);
    check("R8 act blocked on ldn 0", {15'd0, mbx_active}, 16'h0000);
    reg_wr(8'h07, 8'h09);
    reg_rd(8'h07, d); check("R7 selector", {8'd0, d}, 16'h0009);
    reg_wr(8'h30, 8'hFF);
    check("R11 active out", {15'd0, mbx_active}, 16'h0001);
    reg_rd(8'h30, d); check("R8 act reg", {8'd0, d}, 16'h0001);
    reg_wr(8'h60, 8'h12);
    reg_wr(8'h61, 8'h34);
    check("R11 base out", mbx_base, 16'h1234);
    reg_rd(8'h60, d); check("R8 base high", {8'd0, d}, 16'h0012);
    reg_wr(8'h07, 8'h03);
    reg_rd(8'h60, d); check("R8 other ldn reads 0", {8'd0, d}, 16'h0000);
    wr(ia + 16'd1, 8'hFF);
    check("R8 other ldn write ignored", mbx_base, 16'h1234);
    reg_rd(8'h42, d); check("R12 unmapped", {8'd0, d}, 16'h0000);
    reg_wr(8'h07, 8'h09);
    // same-cycle data read and write (R10)
    wr(ia, 8'h61);
    @(negedge clk);
    io_addr = ia + 16'd1; io_wdata = 8'h77; io_wr = 1'b1; io_rd = 1'b1;
    #1 d = io_rdata;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    check("R10 data read before write", {8'd0, d}, 16'h0034);
    rd(ia + 16'd1, d); check("R10 write landed", {8'd0, d}, 16'h0077);
    reg_wr(8'h61, 8'h34);
  endtask

  task automatic t_exit;
    logic [7:0] d;
    wr(ia, 8'h61);
    @(negedge clk);
    io_addr = ia; io_wdata = 8'hAA; io_wr = 1'b1; io_rd = 1'b1;
    #1 d = io_rdata;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    check("R10 index read with exit key", {8'd0, d}, 16'h0061);
    rd(ia, d); check("R3 locked after exit", {8'd0, d}, 16'h00FF);
    wr(ia + 16'd1, 8'h99);
    check("R5 locked write ignored", mbx_base, 16'h1234);
    wr(ia, 8'h55);
    rd(ia, d); check("R3 index kept", {8'd0, d}, 16'h0061);
    rd(ia + 16'd1, d); check("R5 register untouched", {8'd0, d}, 16'h0034);
    wr(ia, 8'hAA);
  endtask

  task automatic t_strap;
    logic [7:0] d;
    strap_alt = 1'b1;
    wr(16'h002E, 8'h55);
    rd(16'h004E, d); check("R1 primary ignored under strap", {8'd0, d}, 16'h00FF);
    wr(16'h0100, 8'h55);
    rd(16'h004E, d); check("R1 foreign addr ignored", {8'd0, d}, 16'h00FF);
    wr(16'h004E, 8'h55);
    rd(16'h004E, d); check("R1 alt index", {8'd0, d}, 16'h0061);
    rd(16'h004F, d); check("R1 alt data", {8'd0, d}, 16'h0034);
    rd(16'h002E, d); check("R1 primary silent", {8'd0, d}, 16'h00FF);
    rd(16'h0100, d); check("R1 foreign read", {8'd0, d}, 16'h00FF);
    wr(16'h004E, 8'hAA);
    rd(16'h004E, d); check("R3 alt exit", {8'd0, d}, 16'h00FF);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_keys();
        t_mailbox();
        t_exit();
        t_strap();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule